// File: doc/BRIEF.md
# UART Interrupt Identification and Line Status Unit

This block holds the interrupt-enable state of a 16550-style serial port and works out which interrupt, if any, the port reports. Four sources compete for the interrupt: a sticky receiver overrun, received characters waiting, a pending transmit-empty event, and a modem-status change. Each source is masked by its own enable bit. The sources are ranked by a fixed priority, and the winner appears as a code in the identification register. A single level-sensitive interrupt line is high while any enabled source is active.

The host reaches three registers over a simple register bus with a 3-bit address and read and write strobes. The enable register is at address 1. The identification register is read at address 2. The line-status register is read at address 5. Read data is combinational from the current state and inputs. The side effects of a read take effect at the clock edge that ends the access.

The neighbouring logic supplies these status signals:
- the receive character count;
- a one-cycle overrun pulse;
- a strobe for each write to the transmit data register;
- a level that is high while a modem delta is pending;
- the FIFO-enable state.

Top module: `uart_irq_ident`

## Requirements
- R1: A write to address 1 stores bits 3:0 of the write data in the enable register (bit 0 receive, bit 1 transmit empty, bit 2 line status, bit 3 modem). A read of address 1 returns those four bits with bits 7:4 as zero. The register resets to 0.
- R2: The reported source is chosen by priority, highest first: overrun with bit 2 enabled, then receive count > 0 with bit 0 enabled, then transmit pending with bit 1 enabled, then modem delta with bit 3 enabled.
- R3: A read of address 2 returns the reason code in bits 3:0, and bits 5:4 read as 0. The codes are: receive data 1100, none 0001, line status 0110, transmit 0010, modem 0000.
- R4: Each cycle with the transmit-data write strobe high sets the transmit-pending flag from the next cycle.
- R5: The transmit-pending flag clears only after a read of address 2 whose returned code is 0010. A write strobe in the same cycle as that read leaves the flag set.
- R6: Identification bits 7:6 read as 11 while FIFO enable is high and as 00 while it is low.
- R7: The interrupt output is high exactly when the current code is not 0001. It follows input changes and the results of register accesses without any software action.
- R8: A read of address 5 returns bit 6 = 1, bit 5 = 1, bit 1 = overrun flag, bit 0 = (receive count > 0), and all other bits 0. The overrun flag is clear after the read.
- R9: Writes to address 5 change neither the overrun flag nor any line-status bit.
- R10: An overrun pulse sets the overrun flag. A pulse that coincides with a line-status read leaves the flag set for the following read.
- R11: After reset the identification read is 0x01, the line-status read is 0x60 with a zero count, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 3 | Register address |
| reg_rd_i | input | 1 | Read strobe, one cycle per access |
| reg_wr_i | input | 1 | Write strobe, one cycle per access |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register; 0 for other addresses |
| rx_count_i | input | CNT_W | Characters held in the receive store |
| overrun_i | input | 1 | One-cycle receive overrun event |
| thr_wr_i | input | 1 | Transmit data register write strobe |
| modem_delta_i | input | 1 | Modem status delta pending |
| fifo_en_i | input | 1 | FIFO mode enabled |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench stacks all four sources at once and walks them down one by one. A design with the priority order wrong, or with the timeout code swapped for the plain data code, would return the wrong code at some step. It checks that reading the identification register while a higher source wins leaves the transmit-pending flag set. A design that cleared the flag on any identification read would lose the transmit interrupt. It also drives an overrun pulse into the same cycle as a line-status read, and a transmit strobe into the same cycle as the clearing identification read. A design that let the clear win in either case would drop an event. Finally it writes all-ones to the line-status address and checks that the next read is unchanged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_IER = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_IIR = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LSR = 3'd5;

  localparam int NUM_SRC   = 4;
  localparam int IER_RX    = 0;
  localparam int IER_TX    = 1;
  localparam int IER_LINE  = 2;
  localparam int IER_MODEM = 3;

  typedef enum logic [3:0] {
    RSN_MODEM = 4'b0000,
    RSN_NONE  = 4'b0001,
    RSN_TX    = 4'b0010,
    RSN_LINE  = 4'b0110,
    RSN_TOUT  = 4'b1100
  } reason_e;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
endpackage

// File: rtl/uart_ier_reg.sv
module uart_ier_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ier_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ier_o <= '0;
    else if (we_i) ier_o <= wdata_i;
  end
endmodule

// File: rtl/uart_thre_flag.sv
module uart_thre_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic pend_o
);
  // a new write outranks the acknowledge in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (ack_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/uart_lsr_status.sv
module uart_lsr_status #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             overrun_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] rx_count_i,
  output logic             oe_o,
  output logic [7:0]       lsr_o
);
  import uart_irq_pkg::*;

  // event set outranks read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_o <= 1'b0;
    else if (overrun_i) oe_o <= 1'b1;
    else if (rd_i)      oe_o <= 1'b0;
  end

  always_comb begin
    lsr_o           = '0;
    lsr_o[LSR_DR]   = (rx_count_i != '0);
    lsr_o[LSR_OE]   = oe_o;
    lsr_o[LSR_THRE] = 1'b1;
    lsr_o[LSR_TEMT] = 1'b1;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_i,   // ordered highest priority first
  input  logic [NUM_SRC-1:0] en_i,
  output reason_e            reason_o,
  output logic               irq_o
);
  localparam reason_e CODES [NUM_SRC] = '{RSN_LINE, RSN_TOUT, RSN_TX, RSN_MODEM};

  logic [NUM_SRC-1:0] act;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_act
    assign act[g] = src_i[g] & en_i[g];
  end

  always_comb begin
    reason_o = RSN_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act[i]) reason_o = CODES[i];
    end
  end

  assign irq_o = |act;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              overrun_i,
  input  logic              thr_wr_i,
  input  logic              modem_delta_i,
  input  logic              fifo_en_i,
  output logic              irq_o
);
  logic [NUM_SRC-1:0] ier_q;
  logic               thre_pend;
  logic               oe_q;
  logic [7:0]         lsr_val;
  logic [7:0]         iir_val;
  reason_e            reason;
  logic               rd_iir, rd_lsr, rd_ier, wr_ier;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata_i[7:NUM_SRC];

  assign rd_ier = reg_rd_i && (reg_addr_i == ADDR_IER);
  assign rd_iir = reg_rd_i && (reg_addr_i == ADDR_IIR);
  assign rd_lsr = reg_rd_i && (reg_addr_i == ADDR_LSR);
  assign wr_ier = reg_wr_i && (reg_addr_i == ADDR_IER);

  uart_ier_reg #(.W(NUM_SRC)) u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ier),
    .wdata_i (reg_wdata_i[NUM_SRC-1:0]),
    .ier_o   (ier_q)
  );

  uart_thre_flag u_thre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (thr_wr_i),
    .ack_i  (rd_iir && (reason == RSN_TX)),
    .pend_o (thre_pend)
  );

  uart_lsr_status #(.CNT_W(CNT_W)) u_lsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .overrun_i  (overrun_i),
    .rd_i       (rd_lsr),
    .rx_count_i (rx_count_i),
    .oe_o       (oe_q),
    .lsr_o      (lsr_val)
  );

  uart_irq_prio u_prio (
    .src_i    ({modem_delta_i, thre_pend, (rx_count_i != '0), oe_q}),
    .en_i     ({ier_q[IER_MODEM], ier_q[IER_TX], ier_q[IER_RX], ier_q[IER_LINE]}),
    .reason_o (reason),
    .irq_o    (irq_o)
  );

  assign iir_val = {{2{fifo_en_i}}, 2'b00, reason};

  always_comb begin
    unique case (reg_addr_i)
      ADDR_IER: reg_rdata_o = {{(8-NUM_SRC){1'b0}}, ier_q};
      ADDR_IIR: reg_rdata_o = iir_val;
      ADDR_LSR: reg_rdata_o = lsr_val;
      default:  reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [7:0]        reg_rdata_o,
  input logic [CNT_W-1:0]  rx_count_i,
  input logic              overrun_i,
  input logic              thr_wr_i,
  input logic              fifo_en_i,
  input logic              irq_o,
  input logic              thre_pend,
  input logic              oe_q,
  input logic [3:0]        ier_q
);
  assert_ier_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_IER) |-> reg_rdata_o[7:4] == 4'h0);

  assert_line_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_IIR && oe_q && ier_q[IER_LINE])
      |-> reg_rdata_o[3:0] == 4'b0110);

  assert_thre_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> thre_pend);

  assert_thre_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thre_pend && !(reg_rd_i && reg_addr_i == ADDR_IIR)) |=> thre_pend);

  assert_fifo_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_IIR) |-> reg_rdata_o[7:6] == {2{fifo_en_i}});

  assert_masked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_q == 4'h0) |-> !irq_o);

  assert_lsr_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_LSR)
      |-> (reg_rdata_o[6:5] == 2'b11 && reg_rdata_o[0] == (rx_count_i != '0)));

  assert_lsr_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == ADDR_LSR && !reg_rd_i && !overrun_i) |=> $stable(oe_q));

  assert_overrun_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> oe_q);
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rdata_o (reg_rdata_o),
  .rx_count_i  (rx_count_i),
  .overrun_i   (overrun_i),
  .thr_wr_i    (thr_wr_i),
  .fifo_en_i   (fifo_en_i),
  .irq_o       (irq_o),
  .thre_pend   (thre_pend),
  .oe_q        (oe_q),
  .ier_q       (ier_q)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int FIFO_DEPTH = 16;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       addr = '0;
  logic             rd = 1'b0, wr = 1'b0;
  logic [7:0]       wdata = '0;
  logic [7:0]       rdata;
  logic [CNT_W-1:0] rx_count = '0;
  logic             ovr = 1'b0, thr = 1'b0, mdelta = 1'b0, fifo_en = 1'b0;
  logic             irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(FIFO_DEPTH)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .reg_addr_i    (addr),
    .reg_rd_i      (rd),
    .reg_wr_i      (wr),
    .reg_wdata_i   (wdata),
    .reg_rdata_o   (rdata),
    .rx_count_i    (rx_count),
    .overrun_i     (ovr),
    .thr_wr_i      (thr),
    .modem_delta_i (mdelta),
    .fifo_en_i     (fifo_en),
    .irq_o         (irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // read with optional coincident strobes
  task automatic rd_ev(input logic [2:0] a, input logic t, input logic o, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1; thr = t; ovr = o;
    #1 d = rdata;
    @(posedge clk);
    #1 rd = 1'b0; thr = 1'b0; ovr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    rd_ev(a, 1'b0, 1'b0, d);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wr = 1'b1; wdata = v;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic pulse(input logic t, input logic o);
    @(negedge clk);
    thr = t; ovr = o;
    @(posedge clk);
    #1 thr = 1'b0; ovr = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R11 irq after reset", {7'b0, irq}, 8'h00);
    rd_reg(3'd2, d); check("R11 iir after reset", d, 8'h01);
    rd_reg(3'd5, d); check("R11 lsr after reset", d, 8'h60);
    rd_reg(3'd1, d); check("R1 ier after reset", d, 8'h00);
  endtask

  task automatic t_ier_mask;
    logic [7:0] d;
    wr_reg(3'd1, 8'hFF);
    rd_reg(3'd1, d); check("R1 ier upper bits", d, 8'h0F);
    wr_reg(3'd1, 8'hA5);
    rd_reg(3'd1, d); check("R1 ier pattern", d, 8'h05);
  endtask

  task automatic t_thre_basic;
    logic [7:0] d;
    wr_reg(3'd1, 8'h02);
    pulse(1'b1, 1'b0);
    check("R4 irq after data write", {7'b0, irq}, 8'h01);
    rd_reg(3'd2, d); check("R3 tx code", d, 8'h02);
    rd_reg(3'd2, d); check("R5 cleared after read", d, 8'h01);
    check("R7 irq low after clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_thre_coincident;
    logic [7:0] d;
    pulse(1'b1, 1'b0);
    rd_ev(3'd2, 1'b1, 1'b0, d); check("R5 read with new write", d, 8'h02);
    rd_reg(3'd2, d); check("R5 flag kept by new write", d, 8'h02);
    rd_reg(3'd2, d); check("R5 flag cleared", d, 8'h01);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    wr_reg(3'd1, 8'h0F);
    rx_count = 5'd1; mdelta = 1'b1;
    pulse(1'b1, 1'b1);
    rd_reg(3'd2, d); check("R2 line first", d, 8'h06);
    rd_reg(3'd5, d); check("R8 lsr with oe and data", d, 8'h63);
    rd_reg(3'd2, d); check("R3 rx reports timeout code", d, 8'h0C);
    rx_count = '0;
    rd_reg(3'd2, d); check("R5 tx kept under higher source", d, 8'h02);
    rd_reg(3'd2, d); check("R2 modem last", d, 8'h00);
    check("R7 irq for modem", {7'b0, irq}, 8'h01);
    mdelta = 1'b0;
    #1 check("R7 irq drops with delta", {7'b0, irq}, 8'h00);
    rd_reg(3'd2, d); check("R3 none code", d, 8'h01);
  endtask

  task automatic t_masked;
    logic [7:0] d;
    wr_reg(3'd1, 8'h00);
    rx_count = 5'd3; mdelta = 1'b1;
    pulse(1'b1, 1'b1);
    check("R7 all masked irq", {7'b0, irq}, 8'h00);
    rd_reg(3'd2, d); check("R2 masked sources", d, 8'h01);
    wr_reg(3'd5, 8'h00);
    rd_reg(3'd5, d); check("R9 oe survives lsr write", d, 8'h63);
    wr_reg(3'd5, 8'hFF);
    rd_reg(3'd5, d); check("R9 lsr write ignored", d, 8'h61);
    rx_count = '0; mdelta = 1'b0;
    pulse(1'b0, 1'b0);
    rd_reg(3'd2, d);
    wr_reg(3'd1, 8'h02);
    rd_reg(3'd2, d); check("R5 tx still pending", d, 8'h02);
  endtask

  task automatic t_rx_event;
    wr_reg(3'd1, 8'h01);
    rx_count = 5'd16;
    #1 check("R7 irq on receive event", {7'b0, irq}, 8'h01);
    rx_count = '0;
    #1 check("R7 irq off when drained", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_fifo_bits;
    logic [7:0] d;
    fifo_en = 1'b1;
    rd_reg(3'd2, d); check("R6 fifo bits set", d, 8'hC1);
    fifo_en = 1'b0;
    rd_reg(3'd2, d); check("R6 fifo bits clear", d, 8'h01);
  endtask

  task automatic t_overrun_coincident;
    logic [7:0] d;
    rd_ev(3'd5, 1'b0, 1'b1, d); check("R10 read during event", d, 8'h60);
    rd_reg(3'd5, d); check("R10 oe kept for next read", d, 8'h62);
    rd_reg(3'd5, d); check("R8 oe cleared by read", d, 8'h60);
  endtask

  initial begin
    #6 rst_n = 1'b1;
    #5;
    t_reset();
    t_ier_mask();
    t_thre_basic();
    t_thre_coincident();
    t_priority();
    t_masked();
    t_rx_event();
    t_fifo_bits();
    t_overrun_coincident();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule